// File: doc/BRIEF.md
# Multi-Link Readout Request Sequencer

This block drives event readout from four front-end links at once. A start command sets off a walk over three nested indices (front-end card, ASIC, channel). For each index tuple the block consults an external lookup entry, then sends a readout request to every link named in an enable mask. It waits until each enabled link has returned its reply or until a programmable cycle limit runs out, and then moves on to the next tuple.

Before any request leaves, the block checks the free space that each of the four receive FIFOs reports. While any FIFO is at or below a configured threshold, the request is held back. A host processor can end a walk at any time with an abort input.

Each request word carries a per-link zero-suppression bit and the three indices. Lookup entries marked as skipped are passed over in one cycle each, and no request is sent for them. When the final tuple has been handled, the block emits a single-cycle completion pulse.

Top module: `readout_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `req_valid`, `tmo_flag`, `stalled` and `evt_done` are all zero, and a request is only ever presented while `busy` is high.
- R2: The walk visits tuples with the channel as the fastest index, then the ASIC, then the card, and each index runs from zero to its count minus one. Each non-skipped tuple is requested exactly once. In each link's request word the channel sits in the lowest bits, the ASIC above it, the card above that, and the zero-suppression bit is the MSB.
- R3: `lut_addr` equals (card × NASIC + asic) × NCHAN + chan for the tuple currently held.
- R4: A request raises `req_valid` for exactly one cycle, with the value equal to `send_en`. Link i's request word carries `zs_mask[i]` as its zero-suppression bit.
- R5: No request is issued while any link's `fifo_free` value is ≤ SPACE_MIN, and `stalled` is high during that hold. Once every link reports more than SPACE_MIN, the request appears in the cycle after the condition clears.
- R6: If every enabled link shows `rx_eop` no later than the cycle in which the timer expires, the next request appears 2 cycles after the cycle of the last such `rx_eop`. Links outside `send_en` count as already answered.
- R7: If the request is presented in cycle c and some enabled link has not answered by cycle c+`tmo_limit`, the sequencer advances at that cycle, and the next request appears at c+`tmo_limit`+2. The sticky `tmo_flag` bit is set for every link that did not answer. All flags clear when a new walk is accepted.
- R8: A final `rx_eop` that lands in the same cycle as timer expiry counts as a completion, and no timeout flag is set.
- R9: A skipped lookup entry costs one cycle and produces no request.
- R10: After the final tuple is handled, `evt_done` pulses high for one cycle in the cycle after that handling, with `busy` low in the same cycle.
- R11: `abort` during a walk returns the block to idle in the next cycle. No further requests and no `evt_done` follow.
- R12: `start_evt` is ignored while busy, and `rx_eop` is ignored when no reply is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_evt | input | 1 | Begin a walk (accepted only when idle) |
| abort | input | 1 | End the walk at once |
| send_en | input | NLINK | Links that receive each request |
| zs_mask | input | NLINK | Per-link zero-suppression choice |
| tmo_limit | input | TMO_W | Reply wait limit in cycles |
| fifo_free | input | NLINK*FREE_W | Free space per receive FIFO, link 0 lowest |
| lut_addr | output | ADDR_W | Flat index of the current tuple |
| lut_skip | input | 1 | Lookup entry at `lut_addr` is to be skipped |
| rx_eop | input | NLINK | Per-link end of reply |
| req_valid | output | NLINK | Request strobe per link |
| req_word | output | NLINK*WORD_W | Request word per link, link 0 lowest |
| tmo_flag | output | NLINK | Sticky per-link timeout record |
| busy | output | 1 | Walk in progress |
| stalled | output | 1 | Request held back for FIFO space |
| evt_done | output | 1 | One-cycle end-of-walk pulse |

## Verification
Two events can fall in the same cycle: the completion of a reply and the expiry of the wait timer. The bench provokes this by setting the reply delay of a responder equal to `tmo_limit`, so the final `rx_eop` arrives in the cycle the timer reaches zero. The verdict rests on two observations. First, the next request must appear at the same cycle offset as a timeout would give. Second, `tmo_flag` must stay clear, which is what separates this case from a delay one cycle longer, where every enabled flag has to set.

// File: rtl/readout_seq_pkg.sv
package readout_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_t;

  // Flat lookup index: channel fastest, card slowest.
  function automatic int unsigned flat_index(input int unsigned card,
                                             input int unsigned asic,
                                             input int unsigned chan,
                                             input int unsigned n_asic,
                                             input int unsigned n_chan);
    return (card * n_asic + asic) * n_chan + chan;
  endfunction

endpackage

// File: rtl/seq_index_walk.sv
module seq_index_walk #(
  parameter int NCARD = 6,
  parameter int NASIC = 4,
  parameter int NCHAN = 79,
  localparam int CARD_W = $clog2(NCARD),
  localparam int ASIC_W = $clog2(NASIC),
  localparam int CHAN_W = $clog2(NCHAN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [CARD_W-1:0] card,
  output logic [ASIC_W-1:0] asic,
  output logic [CHAN_W-1:0] chan,
  output logic              last
);
  localparam logic [CARD_W-1:0] CARD_MAX = CARD_W'(NCARD - 1);
  localparam logic [ASIC_W-1:0] ASIC_MAX = ASIC_W'(NASIC - 1);
  localparam logic [CHAN_W-1:0] CHAN_MAX = CHAN_W'(NCHAN - 1);

  logic chan_wrap, asic_wrap;
  assign chan_wrap = (chan == CHAN_MAX);
  assign asic_wrap = (asic == ASIC_MAX);
  assign last      = chan_wrap && asic_wrap && (card == CARD_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      card <= '0;
      asic <= '0;
      chan <= '0;
    end else if (step) begin
      if (chan_wrap) begin
        chan <= '0;
        if (asic_wrap) begin
          asic <= '0;
          card <= (card == CARD_MAX) ? '0 : card + 1'b1;
        end else begin
          asic <= asic + 1'b1;
        end
      end else begin
        chan <= chan + 1'b1;
      end
    end
  end
endmodule

// File: rtl/seq_reply_track.sv
module seq_reply_track #(
  parameter int NLINK = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NLINK-1:0] load_mask,
  input  logic             in_wait,
  input  logic [NLINK-1:0] eop,
  input  logic             tmo_hit,
  input  logic             clr_flags,
  output logic             all_done,
  output logic [NLINK-1:0] tmo_flag
);
  logic [NLINK-1:0] pending;

  assign all_done = ~|(pending & ~eop);

  for (genvar i = 0; i < NLINK; i++) begin : g_link
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pending[i] <= 1'b0;
      end else if (load) begin
        pending[i] <= load_mask[i];
      end else if (in_wait && eop[i]) begin
        pending[i] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n || clr_flags) begin
        tmo_flag[i] <= 1'b0;
      end else if (tmo_hit && pending[i] && !eop[i]) begin
        tmo_flag[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/seq_reply_timer.sv
module seq_reply_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMO_W-1:0] limit,
  input  logic             run,
  output logic             expired
);
  logic [TMO_W-1:0] cnt;

  assign expired = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= limit;
    end else if (run && !expired) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/readout_seq.sv
module readout_seq
  import readout_seq_pkg::*;
#(
  parameter int NLINK     = 4,
  parameter int NCARD     = 6,
  parameter int NASIC     = 4,
  parameter int NCHAN     = 79,
  parameter int FREE_W    = 16,
  parameter int SPACE_MIN = 2048,
  parameter int TMO_W     = 16,
  localparam int CARD_W = $clog2(NCARD),
  localparam int ASIC_W = $clog2(NASIC),
  localparam int CHAN_W = $clog2(NCHAN),
  localparam int ADDR_W = $clog2(NCARD * NASIC * NCHAN),
  localparam int WORD_W = 1 + CARD_W + ASIC_W + CHAN_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_evt,
  input  logic                    abort,
  input  logic [NLINK-1:0]        send_en,
  input  logic [NLINK-1:0]        zs_mask,
  input  logic [TMO_W-1:0]        tmo_limit,
  input  logic [NLINK*FREE_W-1:0] fifo_free,
  output logic [ADDR_W-1:0]       lut_addr,
  input  logic                    lut_skip,
  input  logic [NLINK-1:0]        rx_eop,
  output logic [NLINK-1:0]        req_valid,
  output logic [NLINK*WORD_W-1:0] req_word,
  output logic [NLINK-1:0]        tmo_flag,
  output logic                    busy,
  output logic                    stalled,
  output logic                    evt_done
);
  seq_state_t state, state_nx;

  logic [CARD_W-1:0] card;
  logic [ASIC_W-1:0] asic;
  logic [CHAN_W-1:0] chan;
  logic              last;

  // Named internal events (also observed by the bound checker)
  logic             start_acc, in_check, in_wait;
  logic             skip_now, issue, wait_end, tmo_hit;
  logic             advance, step, finish;
  logic             all_done, expired, space_low;
  logic [NLINK-1:0] link_low;

  for (genvar i = 0; i < NLINK; i++) begin : g_space
    assign link_low[i] = (fifo_free[i*FREE_W +: FREE_W] <= FREE_W'(SPACE_MIN));
  end
  assign space_low = |link_low;

  assign start_acc = (state == ST_IDLE) && start_evt;
  assign in_check  = (state == ST_CHECK);
  assign in_wait   = (state == ST_WAIT);
  assign skip_now  = in_check && !abort && lut_skip;
  assign stalled   = in_check && !abort && !lut_skip && space_low;
  assign issue     = in_check && !abort && !lut_skip && !space_low;
  assign wait_end  = in_wait && !abort && (all_done || expired);
  assign tmo_hit   = in_wait && !abort && !all_done && expired;
  assign advance   = skip_now || wait_end;
  assign step      = advance && !last;
  assign finish    = advance && last;
  assign busy      = (state != ST_IDLE);

  assign lut_addr = ADDR_W'(flat_index(32'(card), 32'(asic), 32'(chan),
                                       NASIC, NCHAN));

  seq_index_walk #(.NCARD(NCARD), .NASIC(NASIC), .NCHAN(NCHAN)) u_walk (
    .clk  (clk),
    .rst_n(rst_n),
    .clear(start_acc),
    .step (step),
    .card (card),
    .asic (asic),
    .chan (chan),
    .last (last)
  );

  seq_reply_track #(.NLINK(NLINK)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (issue),
    .load_mask(send_en),
    .in_wait  (in_wait),
    .eop      (rx_eop),
    .tmo_hit  (tmo_hit),
    .clr_flags(start_acc),
    .all_done (all_done),
    .tmo_flag (tmo_flag)
  );

  seq_reply_timer #(.TMO_W(TMO_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (issue),
    .limit  (tmo_limit),
    .run    (in_wait),
    .expired(expired)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (start_evt) state_nx = ST_CHECK;
      ST_CHECK: begin
        if (abort)       state_nx = ST_IDLE;
        else if (issue)  state_nx = ST_WAIT;
        else if (finish) state_nx = ST_IDLE;
      end
      ST_WAIT: begin
        if (abort)         state_nx = ST_IDLE;
        else if (wait_end) state_nx = last ? ST_IDLE : ST_CHECK;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      req_valid <= '0;
      evt_done  <= 1'b0;
    end else begin
      state     <= state_nx;
      req_valid <= issue ? send_en : '0;
      evt_done  <= finish;
    end
  end

  for (genvar i = 0; i < NLINK; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        req_word[i*WORD_W +: WORD_W] <= '0;
      end else if (issue) begin
        req_word[i*WORD_W +: WORD_W] <= {zs_mask[i], card, asic, chan};
      end
    end
  end
endmodule

// File: rtl/readout_seq_chk.sv
module readout_seq_chk #(
  parameter int NLINK     = 4,
  parameter int FREE_W    = 16,
  parameter int SPACE_MIN = 2048
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    abort,
  input logic [NLINK-1:0]        send_en,
  input logic [NLINK*FREE_W-1:0] fifo_free,
  input logic [NLINK-1:0]        req_valid,
  input logic [NLINK-1:0]        tmo_flag,
  input logic                    busy,
  input logic                    evt_done,
  input logic                    issue,
  input logic                    tmo_hit,
  input logic                    start_acc
);
  logic any_low;
  always_comb begin
    any_low = 1'b0;
    for (int i = 0; i < NLINK; i++)
      if (fifo_free[i*FREE_W +: FREE_W] <= FREE_W'(SPACE_MIN)) any_low = 1'b1;
  end

  a_r1_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid != '0) |-> busy);

  a_r4_req_mask: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (req_valid == $past(send_en)));

  a_r4_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> !issue);

  a_r5_space_gate: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> !any_low);

  a_r7_flag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!tmo_hit && !start_acc) |=> $stable(tmo_flag));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |=> !evt_done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |-> !busy);

  a_r11_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && busy) |=> (!busy && req_valid == '0));
endmodule

bind readout_seq readout_seq_chk #(
  .NLINK(NLINK), .FREE_W(FREE_W), .SPACE_MIN(SPACE_MIN)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .abort    (abort),
  .send_en  (send_en),
  .fifo_free(fifo_free),
  .req_valid(req_valid),
  .tmo_flag (tmo_flag),
  .busy     (busy),
  .evt_done (evt_done),
  .issue    (issue),
  .tmo_hit  (tmo_hit),
  .start_acc(start_acc)
);

// File: tb/tb_readout_seq.sv
module tb_readout_seq;
  localparam int NL = 4, NCD = 2, NAS = 2, NCH = 3;
  localparam int NIDX = NCD * NAS * NCH;
  localparam int FW = 16, TW = 8, SMIN = 2048;
  localparam int ADW = 4, WW = 5;

  logic clk = 1'b0, rst_n = 1'b0, start_evt = 1'b0, abort = 1'b0;
  logic [NL-1:0] send_en = '0, zs_mask = '0, rx_eop = '0;
  logic [TW-1:0] tmo_limit = '0;
  logic [NL*FW-1:0] fifo_free;
  logic [ADW-1:0] lut_addr;
  logic lut_skip;
  logic [NL-1:0] req_valid, tmo_flag;
  logic [NL*WW-1:0] req_word;
  logic busy, stalled, evt_done;
  logic [NIDX-1:0] skip_pat = '0;

  assign lut_skip = (int'(lut_addr) < NIDX) ? skip_pat[lut_addr] : 1'b0;

  readout_seq #(.NLINK(NL), .NCARD(NCD), .NASIC(NAS), .NCHAN(NCH),
                .FREE_W(FW), .SPACE_MIN(SMIN), .TMO_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .abort(abort),
    .send_en(send_en), .zs_mask(zs_mask), .tmo_limit(tmo_limit),
    .fifo_free(fifo_free), .lut_addr(lut_addr), .lut_skip(lut_skip),
    .rx_eop(rx_eop), .req_valid(req_valid), .req_word(req_word),
    .tmo_flag(tmo_flag), .busy(busy), .stalled(stalled), .evt_done(evt_done));

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_err = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Configuration and monitor state
  bit rsp_on = 0;
  logic [NL-1:0] rsp_mask = '0;
  int dly = 0, lim = 0;
  int start_cyc = 0, last_req_cyc = 0, exp_pos = 0, req_cnt = 0, done_cnt = 0;
  int due = -1;

  function automatic int base_gap();
    if (rsp_on && ((rsp_mask & send_en) == send_en) && dly <= lim) return dly + 2;
    return lim + 2;
  endfunction

  always @(negedge clk) begin
    if (req_valid != '0) begin
      int p, skipped, expc;
      p = exp_pos;
      while (p < NIDX && skip_pat[p]) p++;
      skipped = p - exp_pos;
      expc = (req_cnt == 0) ? start_cyc + 2 + skipped
                            : last_req_cyc + base_gap() + skipped;
      chk(cyc == expc, "R6/R7/R9 request cycle", cyc, expc);
      chk(req_valid == send_en, "R4 request mask", int'(req_valid), int'(send_en));
      chk(int'(lut_addr) == p, "R3 lookup address", int'(lut_addr), p);
      for (int i = 0; i < NL; i++) begin
        if (send_en[i]) begin
          logic [WW-1:0] w;
          w = req_word[i*WW +: WW];
          chk(int'(w[1:0]) == p % NCH, "R2 channel field", int'(w[1:0]), p % NCH);
          chk(int'(w[2]) == (p / NCH) % NAS, "R2 asic field", int'(w[2]), (p / NCH) % NAS);
          chk(int'(w[3]) == p / (NCH * NAS), "R2 card field", int'(w[3]), p / (NCH * NAS));
          chk(w[4] == zs_mask[i], "R4 zero-suppress bit", int'(w[4]), int'(zs_mask[i]));
        end
      end
      exp_pos = p + 1;
      last_req_cyc = cyc;
      req_cnt++;
      if (rsp_on) due = cyc + dly;
    end
    if (evt_done) begin
      int expd;
      expd = (req_cnt == 0) ? start_cyc + 1 + NIDX
                            : last_req_cyc + base_gap() - 1 + (NIDX - exp_pos);
      chk(cyc == expd, "R10 done cycle", cyc, expd);
      chk(!busy, "R10 idle with done", int'(busy), 0);
      done_cnt++;
    end
    rx_eop = (rsp_on && cyc == due) ? rsp_mask : '0;
  end

  task automatic begin_event(input logic [NL-1:0] en, input logic [NL-1:0] zs,
                             input logic [NIDX-1:0] skp, input bit ron,
                             input logic [NL-1:0] rmask, input int d, input int l);
    @(negedge clk);
    send_en = en; zs_mask = zs; skip_pat = skp; rsp_on = ron;
    rsp_mask = rmask; dly = d; lim = l; tmo_limit = TW'(l);
    req_cnt = 0; done_cnt = 0; exp_pos = 0; due = -1;
    start_evt = 1'b1; start_cyc = cyc;
    @(negedge clk);
    start_evt = 1'b0;
    chk(tmo_flag == '0, "R7 flags cleared at start", int'(tmo_flag), 0);
  endtask

  task automatic finish_event();
    int act;
    logic [NL-1:0] ok_links, exp_flags;
    for (int k = 0; k < 3000 && done_cnt == 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    act = 0;
    for (int i = 0; i < NIDX; i++) if (!skip_pat[i]) act++;
    ok_links = (rsp_on && dly <= lim) ? rsp_mask : '0;
    exp_flags = (act == 0) ? '0 : (send_en & ~ok_links);
    chk(req_cnt == act, "R2/R9 request count", req_cnt, act);
    chk(done_cnt == 1, "R10 single done pulse", done_cnt, 1);
    chk(!busy, "R10 idle after walk", int'(busy), 0);
    chk(tmo_flag == exp_flags, "R7/R8 timeout flags", int'(tmo_flag), int'(exp_flags));
  endtask

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    fifo_free = {NL{16'd4000}};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy, "R1 reset busy", int'(busy), 0);
    chk(req_valid == '0, "R1 reset request", int'(req_valid), 0);
    chk(tmo_flag == '0, "R1 reset flags", int'(tmo_flag), 0);
    chk(!evt_done && !stalled, "R1 reset done/stall", int'(evt_done), 0);

    // Full response, all links, no skips
    begin_event(4'b1111, 4'b1111, '0, 1, 4'b1111, 3, 20); finish_event();
    // Disabled links count as answered; skips including the final entry
    begin_event(4'b0101, 4'b0011, 12'b1001_0001_0010, 1, 4'b0101, 1, 10); finish_event();
    // Partial answers -> timeout on silent links
    begin_event(4'b1111, 4'b0000, 12'b0000_0100_0001, 1, 4'b0011, 2, 5); finish_event();
    // R8: last reply in the expiry cycle
    begin_event(4'b1111, 4'b1010, '0, 1, 4'b1111, 4, 4); finish_event();
    // One cycle late: every link flagged, late eop lands while checking (R12)
    begin_event(4'b1111, 4'b0110, '0, 1, 4'b1111, 5, 4); finish_event();
    // Zero limit, no responder
    begin_event(4'b1001, 4'b1001, 12'b0110_0000_0110, 0, 4'b0000, 0, 0); finish_event();
    // R9: everything skipped
    begin_event(4'b1111, 4'b0000, '1, 1, 4'b1111, 1, 5); finish_event();

    // R5: hold while a FIFO is at the threshold, release one above it
    fifo_free[2*FW +: FW] = 16'(SMIN);
    begin_event(4'b1111, 4'b0101, '0, 1, 4'b1111, 2, 9);
    repeat (8) @(negedge clk);
    chk(stalled, "R5 stalled while low", int'(stalled), 1);
    chk(req_cnt == 0, "R5 no request while low", req_cnt, 0);
    fifo_free[2*FW +: FW] = 16'(SMIN + 1);
    start_cyc = cyc - 1;
    finish_event();
    fifo_free = {NL{16'd4000}};

    // R11: abort mid-walk
    begin_event(4'b1111, 4'b1111, '0, 1, 4'b1111, 5, 10);
    while (req_cnt < 3) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(!busy, "R11 idle after abort", int'(busy), 0);
    repeat (40) @(negedge clk);
    chk(req_cnt == 3, "R11 no request after abort", req_cnt, 3);
    chk(done_cnt == 0, "R11 no done after abort", done_cnt, 0);

    // R12: start while busy has no effect on the walk
    begin_event(4'b0110, 4'b0010, 12'b0000_1000_0000, 1, 4'b0110, 2, 8);
    while (req_cnt < 2) @(negedge clk);
    start_evt = 1'b1;
    @(negedge clk);
    start_evt = 1'b0;
    finish_event();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule